// File: doc/BRIEF.md
# Match-Based Watchdog Reset Timer

This peripheral is a watchdog built around one free-running up-counter and one compare value. Software starts the counter, then keeps rewriting it or clearing it before the count reaches the compare value. If the count gets there, the block acts on the match. It can set an interrupt flag, drive a match pin, stop and zero the counter, and send a reset pulse on an internal line, an external line or both. The pulse width comes from a programmable register.

Software can also fire either reset line directly. A debug-halt input can freeze the count when software enables that. A status bit records that the watchdog issued a reset. The power-on reset clears that bit, but the system reset that the block itself caused does not.

Access is through a plain 32-bit register port. The port has a word address, a write strobe, write data and a combinational read path. The eight word registers sit at byte offsets 0x00 to 0x1C, and bus address bits 4:2 select the word.

Top module: `wdt_match_timer`

## Requirements
- R1: After either reset input is low at a clock edge, every register reads zero and irq, match_out, rst_int_o and rst_ext_o are low. Registers: 0x00 flag, 0x04 control, 0x08 count, 0x0C action, 0x10 compare, 0x14 pin control, 0x18 width, 0x1C cause.
- R2: Control bit 0 makes the count advance by one per clock. With that bit clear the count holds. A write to 0x08 loads the count and takes priority over counting in that cycle.
- R3: While control bit 1 is set, the count is held at zero and reads back zero, whatever else is requested.
- R4: When control bit 2 and the dbg_halt input are both high, the count freezes and no match can occur. With control bit 2 clear, dbg_halt has no effect.
- R5: A match is the count equal to the compare value while counting is active. One clock after a match, flag bit 0 at 0x00 is set, whether or not the interrupt is enabled. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. irq is high exactly when the flag is set and action bit 0 is set.
- R6: If action bit 2 is set, a match zeroes the count and clears control bit 0 at the next clock.
- R7: A match with action bit 3 set drives rst_int_o high, and a match with action bit 4 set drives rst_ext_o high. The line goes high one clock after the match and stays high for exactly W+1 clocks, where W is bits 15:0 of 0x18.
- R8: A write to 0x0C with bit 5 set starts an internal pulse at once, and one with bit 6 set starts an external pulse at once. Bits 1, 5 and 6 of 0x0C read back as zero.
- R9: While a pulse is active, writes to 0x04 and 0x08 are ignored. A new match or force cannot restart or lengthen the pulse, and cannot add the other reset line to it.
- R10: At a match, pin-control bits 5:4 act on match_out as follows: 00 holds it, 01 drives it low, 10 drives it high, 11 toggles it. A write to 0x14 sets the mode and sets the pin state from bit 0. Bit 0 of 0x14 reads the current pin state.
- R11: Bit 0 of 0x1C becomes 1 when any reset pulse starts. Bus writes do not change it and sys_rst_n does not clear it; only por_n clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears everything |
| sys_rst_n | input | 1 | System reset, synchronous, active low; clears all but the cause bit |
| dbg_halt | input | 1 | Debugger halt indication |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address; bits 4:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Match interrupt |
| match_out | output | 1 | Match pin |
| rst_int_o | output | 1 | Internal reset pulse |
| rst_ext_o | output | 1 | External reset pulse |

## Verification
The hardest case to reach from the ports is traffic that arrives while a reset pulse is in flight. This includes control and count writes, and a second force of the other reset line. These requests have to land inside a window that software can only open by firing a pulse first. The bench forces a long internal pulse and makes those writes inside it. It then measures the pulse width on a per-clock monitor and reads back that the registers did not change. The match path is swept over several compare values, pulse widths, line selections, stop settings and interrupt enables. For each case the bench works out the first high clock as compare+1 and the width as W+1.

// File: rtl/wdt_match_pkg.sv
// Package: register selectors, bit positions and pin-control encodings
// shared by the watchdog modules and the bench.
package wdt_match_pkg;

    localparam int BUS_AW = 5;

    typedef enum logic [2:0] {
        RG_FLAG  = 3'd0,
        RG_CTRL  = 3'd1,
        RG_COUNT = 3'd2,
        RG_ACT   = 3'd3,
        RG_CMP   = 3'd4,
        RG_PIN   = 3'd5,
        RG_WIDTH = 3'd6,
        RG_CAUSE = 3'd7
    } reg_sel_e;

    localparam int CT_RUN  = 0;
    localparam int CT_ZERO = 1;
    localparam int CT_DBG  = 2;

    localparam int AC_IRQ  = 0;
    localparam int AC_STOP = 2;
    localparam int AC_INT  = 3;
    localparam int AC_EXT  = 4;
    localparam int AC_FINT = 5;
    localparam int AC_FEXT = 6;

    typedef enum logic [1:0] {
        PM_HOLD   = 2'd0,
        PM_LOW    = 2'd1,
        PM_HIGH   = 2'd2,
        PM_TOGGLE = 2'd3
    } pin_mode_e;

endpackage

// File: rtl/wdt_count_unit.sv
// Count unit: up-counter with hold-at-zero, bus load and compare.
// Assumes run already folds in enable, zero-hold and debug freeze.
// hit is combinational; the caller registers any effect of it.
module wdt_count_unit #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold_zero,
    input  logic             stop_on_hit,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);

    // compare is only meaningful while the count is moving
    assign hit = run && (cnt == cmp_val);

    // count update: zero-hold, then bus load, then stop-on-hit, then step
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (hold_zero)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (hit && stop_on_hit)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/wdt_pulse_gen.sv
// Pulse generator: on any trigger while idle, latches which channels
// fired and holds them high for width+1 clocks. Triggers during an
// active pulse are dropped (no retrigger, no channel added).
module wdt_pulse_gen #(
    parameter int PULSE_W = 16,
    parameter int N_CH    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CH-1:0]    trig,
    input  logic [PULSE_W-1:0] width,
    output logic               active,
    output logic [PULSE_W-1:0] left,
    output logic               started,
    output logic [N_CH-1:0]    rst_out
);

    assign started = (|trig) && !active;

    // remaining-length counter and active flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            left   <= '0;
        end else if (started) begin
            active <= 1'b1;
            left   <= width;
        end else if (active) begin
            if (left == '0)
                active <= 1'b0;
            else
                left <= left - 1'b1;
        end
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic sel_q;
        // channel selection captured at pulse start
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_q <= 1'b0;
            else if (started)
                sel_q <= trig[ch];
        end
        assign rst_out[ch] = active && sel_q;
    end

endmodule

// File: rtl/wdt_pin_ctl.sv
// Match pin control: holds a mode and a pin state. A match applies the
// mode (hold/low/high/toggle) and wins over a bus write in that cycle.
module wdt_pin_ctl
    import wdt_match_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       wr,
    input  logic [1:0] wr_mode,
    input  logic       wr_state,
    output logic [1:0] mode,
    output logic       state
);

    pin_mode_e mode_q;
    logic      state_nxt;

    assign mode = mode_q;

    // next pin state: match effect first, then bus write
    always_comb begin
        state_nxt = wr ? wr_state : state;
        if (hit) begin
            unique case (mode_q)
                PM_LOW:    state_nxt = 1'b0;
                PM_HIGH:   state_nxt = 1'b1;
                PM_TOGGLE: state_nxt = ~state;
                default:   state_nxt = wr ? wr_state : state;
            endcase
        end
    end

    // mode and pin state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_HOLD;
            state  <= 1'b0;
        end else begin
            if (wr)
                mode_q <= pin_mode_e'(wr_mode);
            state <= state_nxt;
        end
    end

endmodule

// File: rtl/wdt_match_timer.sv
// Watchdog top: register file, read mux and wiring of the count unit,
// pulse generator and pin control. por_n clears all state; sys_rst_n
// clears all but the reset-cause bit. Both resets are synchronous.
// Assumes CNT_W <= DATA_W and PULSE_W <= DATA_W.
module wdt_match_timer
    import wdt_match_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 32,
    parameter int PULSE_W = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              dbg_halt,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              match_out,
    output logic              rst_int_o,
    output logic              rst_ext_o
);

    localparam int N_CH = 2;

    logic               rst_n;
    reg_sel_e           sel;
    logic               locked;
    logic [2:0]         ctrl_q;
    logic [4:0]         act_q;
    logic [CNT_W-1:0]   cmp_q;
    logic [PULSE_W-1:0] width_q;
    logic               flag_q;
    logic               cause_q;
    logic [CNT_W-1:0]   cnt;
    logic               hit;
    logic               run;
    logic [N_CH-1:0]    trig;
    logic               pulse_active;
    logic [PULSE_W-1:0] pulse_left;
    logic               pulse_started;
    logic [N_CH-1:0]    rst_lines;
    logic [1:0]         pin_mode;
    logic               wr_flag, wr_ctrl, wr_count, wr_act, wr_cmp, wr_pin, wr_width;
    logic               unused_bits;

    assign rst_n  = por_n && sys_rst_n;
    assign sel    = reg_sel_e'(bus_addr[4:2]);
    assign locked = pulse_active;

    assign wr_flag  = bus_we && (sel == RG_FLAG);
    assign wr_ctrl  = bus_we && (sel == RG_CTRL) && !locked;
    assign wr_count = bus_we && (sel == RG_COUNT) && !locked;
    assign wr_act   = bus_we && (sel == RG_ACT);
    assign wr_cmp   = bus_we && (sel == RG_CMP);
    assign wr_pin   = bus_we && (sel == RG_PIN);
    assign wr_width = bus_we && (sel == RG_WIDTH);

    assign unused_bits = ^{bus_addr[1:0], bus_wdata};

    assign run = ctrl_q[CT_RUN] && !ctrl_q[CT_ZERO] && !(ctrl_q[CT_DBG] && dbg_halt);

    // control register: bus write, or run bit dropped by a stopping match
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= bus_wdata[2:0];
        else if (hit && act_q[AC_STOP])
            ctrl_q[CT_RUN] <= 1'b0;
    end

    // match action, compare value and pulse width registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= '0;
            cmp_q   <= '0;
            width_q <= '0;
        end else begin
            if (wr_act)
                act_q <= {bus_wdata[AC_EXT:AC_STOP], 1'b0, bus_wdata[AC_IRQ]};
            if (wr_cmp)
                cmp_q <= bus_wdata[CNT_W-1:0];
            if (wr_width)
                width_q <= bus_wdata[PULSE_W-1:0];
        end
    end

    // match flag: set by a match, cleared by writing 1; set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (wr_flag && bus_wdata[0])
            flag_q <= 1'b0;
    end

    // reset-cause bit: only power-on reset clears it
    always_ff @(posedge clk) begin
        if (!por_n)
            cause_q <= 1'b0;
        else if (pulse_started)
            cause_q <= 1'b1;
    end

    wdt_count_unit #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .hold_zero   (ctrl_q[CT_ZERO]),
        .stop_on_hit (act_q[AC_STOP]),
        .load        (wr_count),
        .load_val    (bus_wdata[CNT_W-1:0]),
        .cmp_val     (cmp_q),
        .cnt         (cnt),
        .hit         (hit)
    );

    assign trig[0] = (hit && act_q[AC_INT]) || (wr_act && bus_wdata[AC_FINT]);
    assign trig[1] = (hit && act_q[AC_EXT]) || (wr_act && bus_wdata[AC_FEXT]);

    wdt_pulse_gen #(.PULSE_W(PULSE_W), .N_CH(N_CH)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .width   (width_q),
        .active  (pulse_active),
        .left    (pulse_left),
        .started (pulse_started),
        .rst_out (rst_lines)
    );

    wdt_pin_ctl u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .wr       (wr_pin),
        .wr_mode  (bus_wdata[5:4]),
        .wr_state (bus_wdata[0]),
        .mode     (pin_mode),
        .state    (match_out)
    );

    assign rst_int_o = rst_lines[0];
    assign rst_ext_o = rst_lines[1];
    assign irq       = flag_q && act_q[AC_IRQ];

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            RG_FLAG:  bus_rdata = DATA_W'(flag_q);
            RG_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            RG_COUNT: bus_rdata = DATA_W'(cnt);
            RG_ACT:   bus_rdata = DATA_W'(act_q);
            RG_CMP:   bus_rdata = DATA_W'(cmp_q);
            RG_PIN:   bus_rdata = DATA_W'({pin_mode, 3'b000, match_out});
            RG_WIDTH: bus_rdata = DATA_W'(width_q);
            RG_CAUSE: bus_rdata = DATA_W'(cause_q);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wdt_match_timer_chk.sv
// Checker for wdt_match_timer, attached by bind. Observes ports and a
// few internal state signals; drives nothing.
module wdt_match_timer_chk #(
    parameter int CNT_W   = 32,
    parameter int PULSE_W = 16
) (
    input logic               clk,
    input logic               por_n,
    input logic               sys_rst_n,
    input logic               bus_we,
    input logic [4:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               hit,
    input logic [4:0]         act_q,
    input logic [2:0]         ctrl_q,
    input logic [CNT_W-1:0]   cnt,
    input logic               flag_q,
    input logic               cause_q,
    input logic               pulse_active,
    input logic [PULSE_W-1:0] pulse_left,
    input logic               rst_int_o
);

    a_r3_zero_hold: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        ctrl_q[1] |=> (cnt == '0));

    a_r5_flag_set: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        hit |=> flag_q);

    a_r6_stop_clears: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (hit && act_q[2] && !bus_we) |=> ((cnt == '0) && !ctrl_q[0]));

    a_r7_pulse_ends: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (pulse_active && pulse_left == '0) |=> !pulse_active);

    a_r8_force_int: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (bus_we && bus_addr[4:2] == 3'd3 && bus_wdata[5] && !pulse_active) |=> rst_int_o);

    a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (pulse_active && pulse_left != '0) |=>
            (pulse_active && pulse_left == PULSE_W'($past(pulse_left) - 1'b1)));

    a_r11_cause_sticky: assert property (@(posedge clk) disable iff (!por_n)
        cause_q |=> cause_q);

endmodule

bind wdt_match_timer wdt_match_timer_chk #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .sys_rst_n    (sys_rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .hit          (hit),
    .act_q        (act_q),
    .ctrl_q       (ctrl_q),
    .cnt          (cnt),
    .flag_q       (flag_q),
    .cause_q      (cause_q),
    .pulse_active (pulse_active),
    .pulse_left   (pulse_left),
    .rst_int_o    (rst_int_o)
);

// File: tb/sim_wdt_match_timer.sv
// Bench for wdt_match_timer: sweeps compare value, pulse width, line
// select, stop and irq enable; then checks the locked window, pin modes,
// debug freeze and the reset-cause bit. Expected values are computed here.
module sim_wdt_match_timer;

    localparam logic [4:0] A_FLAG = 5'h00, A_CTRL = 5'h04, A_COUNT = 5'h08, A_ACT = 5'h0C,
                           A_CMP = 5'h10, A_PIN = 5'h14, A_WIDTH = 5'h18, A_CAUSE = 5'h1C;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        dbg_halt = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, match_out, rst_int_o, rst_ext_o;

    int total = 0;
    int bad = 0;
    int n_int = 0;
    int n_ext = 0;

    always #10 clk = ~clk;

    wdt_match_timer u0 (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .dbg_halt(dbg_halt),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .match_out(match_out), .rst_int_o(rst_int_o), .rst_ext_o(rst_ext_o)
    );

    // per-clock monitor of the reset lines
    always @(negedge clk) begin
        if (rst_int_o) n_int++;
        if (rst_ext_o) n_ext++;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // one match case: returns after the pulse has ended
    task automatic match_case(input int m, input int p, input bit use_ext, input bit stop, input bit ien);
        logic [31:0] v;
        int first, wid, other;
        wr(A_CTRL, 32'd0);
        wr(A_WIDTH, p);
        wr(A_CMP, m);
        wr(A_ACT, {27'd0, use_ext, !use_ext, stop, 1'b0, ien});
        wr(A_FLAG, 32'd1);
        wr(A_CTRL, 32'd2);
        wr(A_CTRL, 32'd1);
        first = -1; wid = 0; other = 0;
        for (int i = 1; i <= m + p + 6; i++) begin
            @(negedge clk);
            if (use_ext ? rst_ext_o : rst_int_o) begin
                if (first < 0) first = i;
                wid++;
            end
            if (use_ext ? rst_int_o : rst_ext_o) other++;
        end
        chk("R7 first pulse clock", first, m + 1);
        chk("R7 pulse width", wid, p + 1);
        chk("R7 other line idle", other, 0);
        rd(A_FLAG, v); chk("R5 flag after match", v, 1);
        chk("R5 irq gated by enable", irq, ien);
        if (stop) begin
            rd(A_CTRL, v); chk("R6 run bit cleared", v, 0);
            rd(A_COUNT, v); chk("R6 count zeroed", v, 0);
        end
    endtask

    // pin-mode match helper: stopping match at compare 3
    task automatic pin_match();
        wr(A_ACT, 32'h4);
        wr(A_CMP, 32'd3);
        wr(A_CTRL, 32'd2);
        wr(A_CTRL, 32'd1);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired got=hang exp=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v, c0;
        repeat (3) @(negedge clk);
        por_n = 1'b1; sys_rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v); chk("R1 register zero after reset", v, 0);
        end
        chk("R1 outputs low", {irq, match_out, rst_int_o, rst_ext_o}, 0);

        // R2: load, hold, count
        wr(A_COUNT, 32'h1234);
        rd(A_COUNT, v); chk("R2 count load", v, 32'h1234);
        repeat (3) @(negedge clk);
        rd(A_COUNT, v); chk("R2 hold when disabled", v, 32'h1234);
        wr(A_CMP, 32'hFFFF_0000);
        wr(A_CTRL, 32'd1);
        rd(A_COUNT, c0);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v); chk("R2 counts one per clock", v, c0 + 5);
        wr(A_COUNT, 32'd100);
        rd(A_COUNT, v); chk("R2 write wins over counting", v, 32'd100);

        // R3: zero hold
        wr(A_CTRL, 32'd3);
        repeat (3) @(negedge clk);
        rd(A_COUNT, v); chk("R3 held at zero", v, 0);
        wr(A_COUNT, 32'd55);
        rd(A_COUNT, v); chk("R3 zero hold beats load", v, 0);

        // R4: debug freeze
        wr(A_CTRL, 32'd5);
        dbg_halt = 1'b1;
        rd(A_COUNT, c0);
        repeat (4) @(negedge clk);
        rd(A_COUNT, v); chk("R4 frozen under halt", v, c0);
        wr(A_CTRL, 32'd1);
        rd(A_COUNT, c0);
        repeat (4) @(negedge clk);
        rd(A_COUNT, v); chk("R4 halt ignored without bit2", v, c0 + 4);
        dbg_halt = 1'b0;
        wr(A_CTRL, 32'd0);

        // R5..R7 sweep
        for (int mi = 0; mi < 4; mi++) begin
            for (int pi = 0; pi < 4; pi++) begin
                match_case((mi == 0) ? 0 : (mi == 1) ? 1 : (mi == 2) ? 4 : 9,
                           (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 3 : 8,
                           pi[0], mi[0] ^ pi[1], mi[1]);
            end
        end

        // R4: halt blocks match
        wr(A_CTRL, 32'd0);
        wr(A_ACT, 32'h1);
        wr(A_FLAG, 32'd1);
        wr(A_CMP, 32'd2);
        wr(A_COUNT, 32'd2);
        dbg_halt = 1'b1;
        wr(A_CTRL, 32'd5);
        repeat (4) @(negedge clk);
        rd(A_FLAG, v); chk("R4 no match while frozen", v, 0);
        dbg_halt = 1'b0;
        @(negedge clk);
        rd(A_FLAG, v); chk("R5 match after unfreeze", v, 1);
        chk("R5 irq high", irq, 1);
        wr(A_FLAG, 32'd0);
        rd(A_FLAG, v); chk("R5 write 0 keeps flag", v, 1);
        wr(A_FLAG, 32'd1);
        rd(A_FLAG, v); chk("R5 write 1 clears flag", v, 0);
        chk("R5 irq low after clear", irq, 0);

        // R8 / R9: forced pulse and locked window
        wr(A_CTRL, 32'd0);
        wr(A_COUNT, 32'd7);
        wr(A_WIDTH, 32'd20);
        n_int = 0; n_ext = 0;
        wr(A_ACT, 32'h20);
        chk("R8 force drives internal line", rst_int_o, 1);
        rd(A_ACT, v); chk("R8 force bits read zero", v, 0);
        wr(A_CTRL, 32'd1);
        wr(A_COUNT, 32'h55);
        wr(A_ACT, 32'h60);
        rd(A_CTRL, v); chk("R9 control write ignored", v, 0);
        rd(A_COUNT, v); chk("R9 count write ignored", v, 7);
        repeat (30) @(negedge clk);
        chk("R9 width not extended", n_int, 21);
        chk("R9 no added external line", n_ext, 0);
        n_ext = 0;
        wr(A_ACT, 32'h40);
        repeat (25) @(negedge clk);
        chk("R8 forced external width", n_ext, 21);
        wr(A_ACT, 32'h1F);
        rd(A_ACT, v); chk("R8 stored action bits", v, 32'h1D);
        wr(A_ACT, 32'h0);

        // R10: pin modes
        wr(A_PIN, 32'h20);
        pin_match();
        chk("R10 mode 10 drives high", match_out, 1);
        rd(A_PIN, v); chk("R10 readback high", v, 32'h21);
        wr(A_PIN, 32'h11);
        chk("R10 write sets pin", match_out, 1);
        pin_match();
        chk("R10 mode 01 drives low", match_out, 0);
        wr(A_PIN, 32'h30);
        pin_match();
        chk("R10 toggle to high", match_out, 1);
        pin_match();
        chk("R10 toggle to low", match_out, 0);
        wr(A_PIN, 32'h01);
        pin_match();
        chk("R10 mode 00 holds", match_out, 1);

        // R11: reset cause
        rd(A_CAUSE, v); chk("R11 cause set", v, 1);
        wr(A_CAUSE, 32'd0);
        rd(A_CAUSE, v); chk("R11 write ignored", v, 1);
        sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1;
        rd(A_CAUSE, v); chk("R11 survives system reset", v, 1);
        rd(A_WIDTH, v); chk("R1 system reset clears width", v, 0);
        por_n = 1'b0; @(negedge clk); por_n = 1'b1;
        rd(A_CAUSE, v); chk("R11 power-on clears cause", v, 0);

        finish_run();
    end

endmodule